// File: doc/BRIEF.md
# X-Tolerant Trace Signature Compactor

This block compresses an 8-bit group of traced debug signals in time. Every cycle that tracing is enabled, the traced byte is folded into a multiple-input signature register (MISR). Once a window of 2^k cycles has been folded, the resulting signature is stored in a 16-entry on-chip trace buffer, and a fresh window starts on the very next cycle. Storing one signature per window, and not every raw sample, cuts the trace volume by a factor of 2^k.

An X-mask byte comes in alongside the traced byte. Any bit flagged as unknown is forced to zero before it reaches the MISR, so an unknown value can never change a signature. The window exponent k is held in a configuration register that can only be written while tracing is off. This lets the window be narrowed from one debug run to the next until a failing interval is pinned down. When all 16 buffer slots hold signatures, tracing halts and a full flag is raised. Stored signatures are read back through a combinational read port.

Top module: `trace_sig_compactor`

## Requirements
- R1: After reset, sig_valid and buf_full are 0 and the window exponent is 0, so each window is one cycle long.
- R2: The MISR state is 8 bits and starts each window at zero. Each traced cycle it becomes ((s<<1) & 0xFF) XOR (0x71 if s[7] is 1, else 0) XOR (trace_data AND NOT xmask). The constant 0x71 encodes x^8+x^6+x^5+x^4+1. The signature of a window is the state after its last sample.
- R3: A trace bit whose xmask bit is 1 has no effect on the signature. With xmask all ones, every signature is 0.
- R4: A window spans 2^k traced cycles, where k is the 3-bit value last written on cfg_k with cfg_wr. sig_valid is high for exactly one cycle, in the cycle after the window's last sample, and sig_data then carries the signature.
- R5: Signatures are stored in order in slots 0 to 15. sig_addr gives the slot written alongside each sig_valid pulse. rd_data returns the slot selected by rd_addr in the same cycle.
- R6: A cfg_wr in a cycle where trace_en is 1 is ignored, and the window length stays unchanged.
- R7: buf_full rises in the same cycle as the 16th sig_valid pulse and stays high until reset. After that, no sig_valid pulse occurs and the buffer contents do not change.
- R8: A cycle with trace_en at 0 discards the partial window. The next traced cycle begins a new window with the MISR at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Write strobe for the window exponent |
| cfg_k | input | 3 | Window exponent k (window length 2^k cycles) |
| trace_en | input | 1 | Enables tracing; 0 abandons the current window |
| trace_data | input | 8 | Traced signal group |
| xmask | input | 8 | 1 marks the matching trace bit as unknown |
| sig_valid | output | 1 | One-cycle pulse when a signature is stored |
| sig_data | output | 8 | Signature stored with sig_valid |
| sig_addr | output | 4 | Buffer slot written with sig_valid |
| buf_full | output | 1 | All buffer slots are used; tracing has stopped |
| rd_addr | input | 4 | Read slot select |
| rd_data | output | 8 | Signature stored in slot rd_addr |

## Verification
Two events can land in the same clock edge. First, the window that writes the last free slot also raises the full flag. Second, a configuration write can arrive while tracing is running. The bench sweeps every window exponent until the buffer is full, and checks that buf_full and the 16th sig_valid rise together and that nothing is written afterwards. It also pulses cfg_wr while tracing is enabled and confirms from the spacing of sig_valid pulses that the window length did not change.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   localparam int TSC_DATA_W = 8;
   localparam int TSC_K_W    = 3;
   localparam int TSC_DEPTH  = 16;
   localparam logic [TSC_DATA_W-1:0] TSC_POLY = 8'h71;

   typedef struct packed {
      logic       valid;
      logic [7:0] sig;
   } tsc_sig_t;
endpackage

// File: rtl/tsc_cfg.sv
module tsc_cfg #(
   parameter int K_W = tsc_pkg::TSC_K_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_wr,
   input  logic [K_W-1:0] cfg_k,
   input  logic           trace_en,
   output logic [K_W-1:0] k_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  k_q <= '0;
      else if (cfg_wr && !trace_en) k_q <= cfg_k;
   end

   // R6
   k_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(trace_en) |-> $stable(k_q));
endmodule

// File: rtl/tsc_window.sv
module tsc_window #(
   parameter int K_W = tsc_pkg::TSC_K_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           active,
   input  logic           clear,
   input  logic [K_W-1:0] k,
   output logic           last
);
   localparam int CNT_W = (1 << K_W) - 1;

   logic [CNT_W:0]   span;
   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] cnt_q;

   assign span = {{CNT_W{1'b0}}, 1'b1} << k;
   assign lim  = span[CNT_W-1:0] - CNT_W'(1);
   assign last = (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clear)  cnt_q <= '0;
      else if (active) cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
   end

   // R4
   win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim);
endmodule

// File: rtl/tsc_misr.sv
module tsc_misr #(
   parameter int                  DATA_W = tsc_pkg::TSC_DATA_W,
   parameter logic [DATA_W-1:0]   POLY   = tsc_pkg::TSC_POLY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              clear,
   input  logic              reload,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] xmask,
   output logic [DATA_W-1:0] next_sig
);
   logic [DATA_W-1:0] state_q;
   logic [DATA_W-1:0] clean;
   logic [DATA_W-1:0] shifted;

   for (genvar b = 0; b < DATA_W; b++) begin : g_mask
      assign clean[b] = din[b] & ~xmask[b];
   end

   assign shifted  = {state_q[DATA_W-2:0], 1'b0} ^ (state_q[DATA_W-1] ? POLY : '0);
   assign next_sig = shifted ^ clean;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= '0;
      else if (clear)  state_q <= '0;
      else if (active) state_q <= reload ? '0 : next_sig;
   end

   // R3
   x_blind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && (&xmask) && (state_q == '0)) |=> (state_q == '0));
endmodule

// File: rtl/tsc_sig_buf.sv
module tsc_sig_buf #(
   parameter int DATA_W = tsc_pkg::TSC_DATA_W,
   parameter int DEPTH  = tsc_pkg::TSC_DEPTH,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [AW-1:0]     wr_slot,
   output logic              full,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [AW:0]       count_q;

   assign wr_slot = count_q[AW-1:0];
   assign full    = count_q[AW];
   assign rd_data = mem_q[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              count_q <= '0;
      else if (wr_en && !full) count_q <= count_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en && !full) mem_q[wr_slot] <= wr_data;
   end

   // R5
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !full) |=> (count_q == $past(count_q) + 1'b1));
   // R7
   full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> full);
endmodule

// File: rtl/trace_sig_compactor.sv
module trace_sig_compactor #(
   parameter int                DATA_W = tsc_pkg::TSC_DATA_W,
   parameter int                K_W    = tsc_pkg::TSC_K_W,
   parameter int                DEPTH  = tsc_pkg::TSC_DEPTH,
   parameter logic [DATA_W-1:0] POLY   = tsc_pkg::TSC_POLY,
   localparam int               AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [K_W-1:0]    cfg_k,
   input  logic              trace_en,
   input  logic [DATA_W-1:0] trace_data,
   input  logic [DATA_W-1:0] xmask,
   output logic              sig_valid,
   output logic [DATA_W-1:0] sig_data,
   output logic [AW-1:0]     sig_addr,
   output logic              buf_full,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   if (DATA_W < 2)                 begin : g_bad_w  $error("DATA_W must be at least 2"); end
   if (K_W < 1 || K_W > 4)         begin : g_bad_k  $error("K_W must be 1 to 4"); end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
                                   begin : g_bad_d  $error("DEPTH must be a power of two"); end
   if (POLY[0] != 1'b1)            begin : g_bad_p  $error("POLY needs its constant term"); end

   logic [K_W-1:0]    k_q;
   logic              active, last, wr_sig;
   logic [DATA_W-1:0] next_sig;
   logic [AW-1:0]     slot;

   assign active = trace_en & ~buf_full;
   assign wr_sig = active & last;

   tsc_cfg #(.K_W(K_W)) i_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_k(cfg_k),
      .trace_en(trace_en), .k_q(k_q));

   tsc_window #(.K_W(K_W)) i_win (
      .clk(clk), .rst_n(rst_n), .active(active), .clear(~trace_en),
      .k(k_q), .last(last));

   tsc_misr #(.DATA_W(DATA_W), .POLY(POLY)) i_misr (
      .clk(clk), .rst_n(rst_n), .active(active), .clear(~trace_en),
      .reload(last), .din(trace_data), .xmask(xmask), .next_sig(next_sig));

   tsc_sig_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_sig), .wr_data(next_sig),
      .wr_slot(slot), .full(buf_full), .rd_addr(rd_addr), .rd_data(rd_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_valid <= 1'b0;
         sig_data  <= '0;
         sig_addr  <= '0;
      end else begin
         sig_valid <= wr_sig;
         if (wr_sig) begin
            sig_data <= next_sig;
            sig_addr <= slot;
         end
      end
   end

   // R7
   no_write_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(buf_full) |-> !sig_valid);
   // R4
   valid_from_trace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sig_valid |-> $past(trace_en));
endmodule

// File: tb/test_trace_sig_compactor.sv
`timescale 1ns/1ps
module test_trace_sig_compactor;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [2:0] cfg_k = '0;
   logic       trace_en = 1'b0;
   logic [7:0] trace_data = '0;
   logic [7:0] xmask = '0;
   logic       sig_valid;
   logic [7:0] sig_data;
   logic [3:0] sig_addr;
   logic       buf_full;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   trace_sig_compactor i_trace_sig_compactor (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_k(cfg_k),
      .trace_en(trace_en), .trace_data(trace_data), .xmask(xmask),
      .sig_valid(sig_valid), .sig_data(sig_data), .sig_addr(sig_addr),
      .buf_full(buf_full), .rd_addr(rd_addr), .rd_data(rd_data));

   // reference state
   int         m_k, m_cnt, m_wp;
   logic [7:0] m_misr;
   logic       m_full, e_valid;
   logic [7:0] e_sig;
   int         e_addr;
   logic [7:0] e_mem [16];
   int unsigned seed = 32'h1234_5678;

   function automatic logic [7:0] ref_step(logic [7:0] s, logic [7:0] d, logic [7:0] m);
      logic [7:0] t;
      t = {s[6:0], 1'b0};
      if (s[7]) t = t ^ 8'h71;
      return t ^ (d & ~m);
   endfunction

   function automatic logic [7:0] rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed[23:16];
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cfg_wr = 0; trace_en = 0; trace_data = 0; xmask = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_k = 0; m_cnt = 0; m_wp = 0; m_misr = 0; m_full = 0;
      e_valid = 0; e_sig = 0; e_addr = 0;
   endtask

   task automatic cyc(input logic en, input logic [7:0] d, input logic [7:0] m,
                      input logic wr, input logic [2:0] wk);
      logic [7:0] nxt;
      @(negedge clk);
      check(sig_valid == e_valid, "R4 sig_valid", sig_valid, e_valid);
      if (e_valid) begin
         check(sig_data == e_sig, "R2 sig_data", sig_data, e_sig);
         check(sig_addr == e_addr[3:0], "R5 sig_addr", sig_addr, e_addr);
      end
      check(buf_full == m_full, "R7 buf_full", buf_full, m_full);
      trace_en = en; trace_data = d; xmask = m; cfg_wr = wr; cfg_k = wk;
      e_valid = 0;
      if (!en) begin
         m_misr = 0; m_cnt = 0;
         if (wr) m_k = wk;
      end else if (!m_full) begin
         nxt = ref_step(m_misr, d, m);
         if (m_cnt == (1 << m_k) - 1) begin
            e_valid = 1; e_sig = nxt; e_addr = m_wp; e_mem[m_wp] = nxt;
            m_wp++; if (m_wp == 16) m_full = 1;
            m_misr = 0; m_cnt = 0;
         end else begin
            m_misr = nxt; m_cnt++;
         end
      end
   endtask

   task automatic readback();
      for (int a = 0; a < 16; a++) begin
         @(negedge clk);
         rd_addr = a[3:0];
         #1;
         check(rd_data == e_mem[a], "R5 rd_data", rd_data, e_mem[a]);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state
      @(negedge clk);
      check(sig_valid == 0, "R1 sig_valid", sig_valid, 0);
      check(buf_full == 0, "R1 buf_full", buf_full, 0);
      // R1: default one-cycle window
      for (int i = 0; i < 4; i++) cyc(1, rnd(), rnd(), 0, 0);
      cyc(0, 0, 0, 0, 0);
      check(m_wp == 4, "R1 window count", m_wp, 4);

      // R4 R5 R7: sweep every exponent until full, with mixed masks
      for (int k = 0; k < 8; k++) begin
         do_reset();
         cyc(0, 0, 0, 1, k[2:0]);
         while (!m_full) cyc(1, rnd(), rnd() & rnd(), 0, 0);
         for (int i = 0; i < 6; i++) cyc(1, rnd(), 0, 0, 0);
         cyc(0, 0, 0, 0, 0);
         readback();
      end

      // R3: everything masked gives zero signatures
      do_reset();
      cyc(0, 0, 0, 1, 3'd2);
      for (int i = 0; i < 16; i++) cyc(1, rnd(), 8'hFF, 0, 0);
      cyc(0, 0, 0, 0, 0);
      for (int a = 0; a < 4; a++) begin
         @(negedge clk); rd_addr = a[3:0]; #1;
         check(rd_data == 8'h00, "R3 masked sig", rd_data, 0);
      end

      // R6: write attempt while tracing keeps 2-cycle window
      do_reset();
      cyc(0, 0, 0, 1, 3'd1);
      cyc(1, rnd(), 0, 1, 3'd5);
      for (int i = 0; i < 8; i++) cyc(1, rnd(), 0, i == 3, 3'd6);
      cyc(0, 0, 0, 0, 0);
      check(m_wp == 4, "R6 window count", m_wp, 4);

      // R8: dropping trace_en discards a partial window
      do_reset();
      cyc(0, 0, 0, 1, 3'd2);
      cyc(1, 8'hA5, 0, 0, 0);
      cyc(1, 8'h3C, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
      for (int i = 0; i < 6; i++) cyc(1, rnd(), 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
      check(m_wp == 1, "R8 window count", m_wp, 1);
      readback();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule